// File: doc/BRIEF.md
# Receiver-Encrypted Segment Sequencer

This block holds one memory segment that runs a one-way life cycle: a receiver-only secret is loaded first, then a payload is combined with it, and after that the segment can only be read. In the first stage a host fills the segment with a key stream, and no read returns any of it. In the second stage a sender writes plaintext. Each incoming byte is XORed with the key byte already stored at the same offset, and the result replaces that key byte in place. Once the last offset has been written in the second stage, the segment becomes read-only. Reads then return only the combined ciphertext, so only the holder of the key stream can recover the payload.

The block is active only while the segment's management model field holds the receiver-encryption code 4. An authorized edit of the model field restarts the life cycle and wipes the segment. Key-stream generation, host-side decryption and PIN checking are handled outside the block.

Top module: `rx_crypt_segment`

## Requirements
- R1: After reset, `stage_o` is 0 and `rdata_o` is 0.
- R2: `stage_o` encodes 0 = key loading, 1 = data loading, 2 = read-many. An accepted write to offset SEG_BYTES-1 moves the stage from 0 to 1, or from 1 to 2. No other write changes the stage.
- R3: In stage 0, an accepted write stores the byte unchanged, and reads return 0.
- R4: In stage 1, an accepted write replaces the stored byte with the stored byte XOR `wdata_i`, and reads return 0.
- R5: In stage 2, a read returns the stored byte on `rdata_o` one cycle after `rd_en_i`, writes are ignored, and the stage stays at 2.
- R6: An offset at or above SEG_BYTES is ignored: the write stores nothing and does not advance the stage, and the read returns 0.
- R7: A pulse on `model_wr_i` sets the stage to 0 and zeroes every byte of the segment, and it takes priority over a write in the same cycle.
- R8: While `model_i` is not 4, writes are ignored, reads return 0 and the stage holds.
- R9: `rdata_o` is 0 in every cycle that does not follow a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| model_i | input | MODEL_W | Current model field of the segment's management area |
| model_wr_i | input | 1 | Authorized edit of the model field: restart and wipe |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | ADDR_W | Byte offset within the segment |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, registered |
| stage_o | output | 2 | Life-cycle stage |

## Verification
The assertions take for granted that `model_wr_i` is a single-cycle pulse issued only for an authorized edit. They also assume that `addr_i` and `wdata_i` are settled whenever a strobe is high. The stimulus drives every input on the falling edge, which keeps these assumptions true. It pulses `model_wr_i` for exactly one cycle, and only once. Offsets past the segment end and a model code other than 4 are applied deliberately, to show that such accesses are turned away without moving the stage.

// File: rtl/rx_seg_pkg.sv
package rx_seg_pkg;
  typedef enum logic [1:0] {
    STG_KEY  = 2'd0,
    STG_DATA = 2'd1,
    STG_READ = 2'd2
  } stage_e;
endpackage

// File: rtl/rx_seg_stage.sv
module rx_seg_stage
  import rx_seg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAST   = 231
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  output stage_e            stage_o
);
  stage_e stage_q, stage_d;
  logic   last_hit;

  assign last_hit = wr_ok_i && (addr_i == ADDR_W'(LAST));

  always_comb begin
    stage_d = stage_q;
    if (clr_i) stage_d = STG_KEY;
    else if (last_hit) begin
      case (stage_q)
        STG_KEY:  stage_d = STG_DATA;
        STG_DATA: stage_d = STG_READ;
        default:  stage_d = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stage_q <= STG_KEY;
    else         stage_q <= stage_d;

  assign stage_o = stage_q;

  assert_stage_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q inside {STG_KEY, STG_DATA, STG_READ});

  assert_advance_on_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q != $past(stage_q)) && !$past(clr_i) |-> $past(wr_ok_i) && ($past(addr_i) == ADDR_W'(LAST)));

  assert_read_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stage_q) == STG_READ) && !$past(clr_i) |-> stage_q == STG_READ);

  assert_clear_to_key_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> stage_q == STG_KEY);
endmodule

// File: rtl/rx_seg_store.sv
module rx_seg_store #(
  parameter int DEPTH  = 232,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic              xor_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // whole-array wipe in one cycle so the restart is atomic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[addr_i] <= xor_i ? (mem_q[addr_i] ^ wdata_i) : wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_o <= 8'h00;
    else if (rd_i) rdata_o <= mem_q[addr_i];
    else           rdata_o <= 8'h00;

  assert_wipe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mem_q[0] == 8'h00) && (mem_q[DEPTH-1] == 8'h00));

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == 8'h00);
endmodule

// File: rtl/rx_crypt_segment.sv
module rx_crypt_segment
  import rx_seg_pkg::*;
#(
  parameter int SEG_BYTES = 232,
  parameter int MODEL_W   = 4,
  parameter int RX_MODEL  = 4,
  localparam int ADDR_W   = $clog2(SEG_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODEL_W-1:0] model_i,
  input  logic               model_wr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [1:0]         stage_o
);
  localparam int LAST = SEG_BYTES - 1;

  stage_e stage;
  logic   model_ok, in_range, wr_ok, rd_ok;

  assign model_ok = (model_i == MODEL_W'(RX_MODEL));
  assign in_range = ({1'b0, addr_i} < (ADDR_W+1)'(SEG_BYTES));
  assign wr_ok    = wr_en_i && model_ok && in_range && !model_wr_i && (stage != STG_READ);
  assign rd_ok    = rd_en_i && model_ok && in_range && (stage == STG_READ);

  rx_seg_stage #(.ADDR_W(ADDR_W), .LAST(LAST)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (model_wr_i),
    .wr_ok_i (wr_ok),
    .addr_i  (addr_i),
    .stage_o (stage)
  );

  rx_seg_store #(.DEPTH(SEG_BYTES), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (model_wr_i),
    .we_i    (wr_ok),
    .xor_i   (stage == STG_DATA),
    .rd_i    (rd_ok),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  assign stage_o = stage;

  assert_no_leak_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != 8'h00) |-> ($past(stage_o) == 2'd2) && $past(rd_en_i));

  assert_model_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !model_ok && !model_wr_i |=> $stable(stage_o));

  assert_range_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !in_range |=> rdata_o == 8'h00);
endmodule

// File: tb/rx_crypt_segment_test.sv
`timescale 1ns/1ps
module rx_crypt_segment_test;
  localparam int SEG = 232;
  localparam int AW  = 8;
  localparam int LST = SEG - 1;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] key;
    logic [7:0] dat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'hFF, 8'hFF},
    '{8'd1,   8'h00, 8'hA5},
    '{8'd2,   8'hA5, 8'h00},
    '{8'd57,  8'h3C, 8'hC3},
    '{8'd115, 8'h81, 8'h18},
    '{8'd200, 8'h12, 8'h34},
    '{8'd230, 8'hF0, 8'h0F},
    '{8'd231, 8'h5A, 8'h5A}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] model = 4'd4;
  logic       model_wr = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] stage;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_crypt_segment uut (
    .clk_i(clk), .rst_ni(rst_n), .model_i(model), .model_wr_i(model_wr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stage_o(stage)
  );

  function automatic logic [7:0] key_of(int i);
    logic [7:0] k = 8'(i * 3 + 1);
    for (int v = 0; v < NV; v++) if (int'(VECS[v].addr) == i) k = VECS[v].key;
    return k;
  endfunction

  function automatic logic [7:0] dat_of(int i);
    logic [7:0] d = ~8'(i);
    for (int v = 0; v < NV; v++) if (int'(VECS[v].addr) == i) d = VECS[v].dat;
    return d;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    chk("R1 stage", {6'd0, stage}, 8'd0);
    chk("R1 rdata", rdata, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: wrong model, write to last offset must not advance
    model = 4'd2;
    wr(LST, 8'h99);
    chk("R8 stage hold", {6'd0, stage}, 8'd0);
    model = 4'd4;

    // R6: out-of-range write must not advance
    wr(240, 8'h11);
    chk("R6 oob write", {6'd0, stage}, 8'd0);

    // key loading (R3)
    for (int i = 0; i < SEG; i++) begin
      wr(i, key_of(i));
      if (i == 5) begin
        rd(0, q);
        chk("R3 key-stage read", q, 8'd0);
        chk("R2 still key", {6'd0, stage}, 8'd0);
      end
    end
    chk("R2 key->data", {6'd0, stage}, 8'd1);

    // data loading (R4)
    for (int i = 0; i < SEG; i++) begin
      wr(i, dat_of(i));
      if (i == 3) begin
        rd(0, q);
        chk("R4 data-stage read", q, 8'd0);
      end
    end
    chk("R2 data->read", {6'd0, stage}, 8'd2);

    // table walk (R4/R5): ciphertext = key ^ data
    for (int v = 0; v < NV; v++) begin
      rd(int'(VECS[v].addr), q);
      chk("R5 read xor", q, VECS[v].key ^ VECS[v].dat);
    end
    rd(100, q);
    chk("R4 default xor", q, key_of(100) ^ dat_of(100));

    // R9: idle cycle after read returns zero
    @(negedge clk);
    chk("R9 idle zero", rdata, 8'd0);

    // R5: writes ignored in read-many
    wr(57, 8'h77);
    rd(57, q);
    chk("R5 write ignored", q, 8'hFF);
    chk("R5 stage sticky", {6'd0, stage}, 8'd2);

    // R6: out-of-range read returns zero
    rd(245, q);
    chk("R6 oob read", q, 8'd0);

    // R8: wrong model hides data
    model = 4'd0;
    rd(1, q);
    chk("R8 read gated", q, 8'd0);
    model = 4'd4;

    // R7: restart with same-cycle write, clear wins
    @(negedge clk);
    model_wr = 1'b1; wr_en = 1'b1; addr = AW'(LST); wdata = 8'hEE;
    @(negedge clk);
    model_wr = 1'b0; wr_en = 1'b0;
    chk("R7 stage to key", {6'd0, stage}, 8'd0);
    wr(LST, 8'h12);
    chk("R7 clear beat write", {6'd0, stage}, 8'd1);
    wr(LST, 8'h34);
    chk("R7 relaunch read", {6'd0, stage}, 8'd2);
    rd(0, q);
    chk("R7 wiped", q, 8'd0);
    rd(LST, q);
    chk("R7 fresh xor", q, 8'h26);

    summary();
  end
endmodule